// File: doc/BRIEF.md
# Nine-Bit Multi-Drop Serial Receiver with Address Filtering

This block is an asynchronous serial receiver for shared multi-drop lines such as RS-485. A frame is a low start bit, eight data bits sent least significant first, an optional ninth bit, and a high stop bit. In nine-bit mode the ninth bit tells an address frame (1) apart from a data frame (0). The received byte and its ninth bit are placed in a one-entry holding buffer, and an interrupt output is raised.

With the address filter on, the receiver drops data frames in hardware. Only address frames reach the buffer, so the host is disturbed only when some node is being addressed. Once the host sees its own address, it turns the filter off and takes every following frame. It turns the filter back on when the exchange ends.

The line is sampled on a tick input that runs at sixteen times the baud rate. The host frees the buffer with a one-cycle read pulse. The ninth-bit, framing-error and overrun outputs may be read at any time while the frame is held.

Top module: `mdrop_rx9`

## Requirements
- R1: After reset, `rx_irq` and `rx_ovr` are 0.
- R2: In nine-bit mode (`nine_bit`=1) a frame with a valid stop bit shows its eight data bits on `rx_data` (first bit received in bit 0) and its ninth bit on `rx_bit9`, and it sets `rx_irq`.
- R3: With `addr_filt`=1 in nine-bit mode, a frame whose ninth bit is 0 is not loaded into the buffer and leaves `rx_irq` at 0.
- R4: With `addr_filt`=1 in nine-bit mode, a frame whose ninth bit is 1 is loaded into the buffer with `rx_bit9`=1, and it sets `rx_irq`.
- R5: With `addr_filt`=0, data frames (ninth bit 0) are loaded and set `rx_irq`.
- R6: A frame that is accepted while the buffer is still full is lost. It sets `rx_ovr`, and the buffered byte stays unchanged.
- R7: `rx_ovr` stays set until `rx_en` is taken low. It stays 0 after `rx_en` returns high.
- R8: The receiver ignores the line unless `port_en`=1, `sync_mode`=0 and `rx_en`=1.
- R9: A stop bit sampled as 0 loads the frame with `rx_ferr`=1. A stop bit sampled as 1 gives `rx_ferr`=0.
- R10: A frame dropped by the address filter changes neither `rx_ferr` nor `rx_ovr`, even when its stop bit is bad or the buffer is full.
- R11: A one-cycle pulse on `rd_buf` empties the buffer and clears `rx_irq` on the next cycle.
- R12: In eight-bit mode (`nine_bit`=0) a frame carries eight data bits, `rx_bit9` reads 0, and the address filter has no effect.
- R13: A low pulse on the line that is shorter than half a bit period does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| os_tick | input | 1 | One-cycle pulse at sixteen times the baud rate |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select; the receiver runs only when it is 0 |
| rx_en | input | 1 | Receive enable; a low level clears the overrun flag |
| nine_bit | input | 1 | 1 selects nine-bit frames |
| addr_filt | input | 1 | 1 drops frames whose ninth bit is 0 (nine-bit mode only) |
| rd_buf | input | 1 | Buffer read pulse; empties the buffer |
| rx_data | output | 8 | Buffered data byte |
| rx_bit9 | output | 1 | Ninth bit of the buffered frame |
| rx_ferr | output | 1 | Framing error of the buffered frame |
| rx_irq | output | 1 | Receive-complete interrupt; high while the buffer is full |
| rx_ovr | output | 1 | Overrun error, sticky |

## Verification
The frame is decided on the tick that takes the third stop-bit sample, about ten ticks into the stop bit. The buffer, `rx_irq` and `rx_ovr` change one clock later. The line passes through two synchronizer flops, and a start edge is seen only on the next tick, so the decision comes at most a few clocks later than that. The bench holds the stop bit for a full bit time and then idles the line for one more bit. It samples all results on a falling clock edge after that, which is well past the update. A read pulse is checked on the falling edge of the cycle after it.

// File: rtl/mdrop_rx9_pkg.sv
package mdrop_rx9_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              ferr;
    } rx_frame_t;
endpackage

// File: rtl/mdrop_rx9_sync.sv
module mdrop_rx9_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mdrop_rx9_frame.sv
module mdrop_rx9_frame
    import mdrop_rx9_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active,
    input  logic      tick,
    input  logic      line,
    input  logic      nine_bit,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CW   = $clog2(OSR);
    localparam int IW   = $clog2(DATA_W + 1);
    localparam int SHW  = DATA_W + 1;
    localparam logic [CW-1:0] SP0  = CW'(OSR/2 - 2);
    localparam logic [CW-1:0] SP1  = CW'(OSR/2 - 1);
    localparam logic [CW-1:0] SP2  = CW'(OSR/2);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef struct packed {
        rx_state_e      st;
        logic [CW-1:0]  cnt;
        logic [IW-1:0]  idx;
        logic [SHW-1:0] sh;
        logic           s0;
        logic           s1;
        logic           done;
        logic           ferr;
    } fr_regs_t;

    fr_regs_t q, d;
    logic          vote;
    logic [IW-1:0] last_idx;

    assign vote     = (q.s0 & q.s1) | (q.s0 & line) | (q.s1 & line);
    assign last_idx = nine_bit ? IW'(DATA_W) : IW'(DATA_W - 1);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!active) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.idx = '0;
        end else if (tick) begin
            case (q.st)
                ST_IDLE: begin
                    if (!line) begin
                        d.st  = ST_START;
                        d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (q.cnt == SP1 && line) begin
                        d.st  = ST_IDLE;
                        d.cnt = '0;
                    end else if (q.cnt == LAST) begin
                        d.st  = ST_BITS;
                        d.cnt = '0;
                        d.idx = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_BITS: begin
                    if (q.cnt == SP0) d.s0 = line;
                    if (q.cnt == SP1) d.s1 = line;
                    if (q.cnt == SP2) d.sh = {vote, q.sh[SHW-1:1]};
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        if (q.idx == last_idx) begin
                            d.st  = ST_STOP;
                            d.idx = '0;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (q.cnt == SP0) d.s0 = line;
                    if (q.cnt == SP1) d.s1 = line;
                    if (q.cnt == SP2) begin
                        d.done = 1'b1;
                        d.ferr = ~vote;
                        d.st   = ST_IDLE;
                        d.cnt  = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.cnt  <= '0;
            q.idx  <= '0;
            q.sh   <= '0;
            q.s0   <= 1'b1;
            q.s1   <= 1'b1;
            q.done <= 1'b0;
            q.ferr <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign done       = q.done;
    assign frame.data = nine_bit ? q.sh[DATA_W-1:0] : q.sh[SHW-1:1];
    assign frame.bit9 = nine_bit ? q.sh[SHW-1] : 1'b0;
    assign frame.ferr = q.ferr;

    // R8: receiver is held idle while not enabled
    a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (q.st == ST_IDLE && !q.done));

    // R13: a start bit seen high at mid-bit returns to idle
    a_r13_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && q.st == ST_START && q.cnt == SP1 && line) |=> q.st == ST_IDLE);
endmodule

// File: rtl/mdrop_rx9_accept.sv
module mdrop_rx9_accept
    import mdrop_rx9_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      done,
    input  rx_frame_t frame,
    input  logic      nine_bit,
    input  logic      addr_filt,
    input  logic      rx_en,
    input  logic      rd,
    output rx_frame_t held,
    output logic      full,
    output logic      ovr
);
    typedef struct packed {
        rx_frame_t buf_f;
        logic      full;
        logic      ovr;
    } acc_regs_t;

    acc_regs_t q, d;
    logic      keep;
    logic      take;
    logic      room;

    assign keep = ~(nine_bit & addr_filt & ~frame.bit9);
    assign take = done & keep;
    assign room = ~q.full | rd;

    always_comb begin
        d = q;
        if (rd) d.full = 1'b0;
        if (take) begin
            if (room) begin
                d.buf_f = frame;
                d.full  = 1'b1;
            end else begin
                d.ovr = 1'b1;
            end
        end
        if (!rx_en) d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.buf_f <= '0;
            q.full  <= 1'b0;
            q.ovr   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign held = q.buf_f;
    assign full = q.full;
    assign ovr  = q.ovr;

    // R3 / R10: a filtered frame leaves buffer and error state untouched
    a_r3_filtered_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nine_bit && addr_filt && !frame.bit9 && !rd && rx_en)
        |=> ($stable(q.full) && $stable(q.buf_f) && $stable(q.ovr)));

    // R6: an accepted frame on a full buffer is lost and flags overrun
    a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (take && q.full && !rd && rx_en) |=> (q.ovr && $stable(q.buf_f)));

    // R11: a read with nothing arriving empties the buffer
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !take) |=> !q.full);

    // R7: overrun is cleared while receive is disabled
    a_r7_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !q.ovr);
endmodule

// File: rtl/mdrop_rx9.sv
module mdrop_rx9
    import mdrop_rx9_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic              addr_filt,
    input  logic              rd_buf,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_ferr,
    output logic              rx_irq,
    output logic              rx_ovr
);
    logic      line_s;
    logic      active;
    logic      f_done;
    rx_frame_t f_frame;
    rx_frame_t held;

    assign active = port_en & ~sync_mode & rx_en;

    mdrop_rx9_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (line_s)
    );

    mdrop_rx9_frame #(.OSR(OSR)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick     (os_tick),
        .line     (line_s),
        .nine_bit (nine_bit),
        .done     (f_done),
        .frame    (f_frame)
    );

    mdrop_rx9_accept u_accept (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (f_done),
        .frame     (f_frame),
        .nine_bit  (nine_bit),
        .addr_filt (addr_filt),
        .rx_en     (rx_en),
        .rd        (rd_buf),
        .held      (held),
        .full      (rx_irq),
        .ovr       (rx_ovr)
    );

    assign rx_data = held.data;
    assign rx_bit9 = held.bit9;
    assign rx_ferr = held.ferr;

    // R1: no interrupt or overrun in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rx_irq && !rx_ovr));
endmodule

// File: tb/mdrop_rx9_tb.sv
module mdrop_rx9_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       port_en = 1'b1;
    logic       sync_mode = 1'b0;
    logic       rx_en = 1'b1;
    logic       nine_bit = 1'b1;
    logic       addr_filt = 1'b0;
    logic       rd_buf = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_ferr, rx_irq, rx_ovr;

    int checks = 0;
    int errors = 0;
    int tdiv   = 0;

    mdrop_rx9 u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .port_en(port_en), .sync_mode(sync_mode), .rx_en(rx_en),
        .nine_bit(nine_bit), .addr_filt(addr_filt), .rd_buf(rd_buf),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_ferr(rx_ferr),
        .rx_irq(rx_irq), .rx_ovr(rx_ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tdiv    <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
        os_tick <= (tdiv == TICK_DIV-1);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        @(negedge clk);
        rx_line = v;
        repeat (BIT_CLKS - 1) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic b9, input logic with9, input logic stop);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        if (with9) hold_bit(b9);
        hold_bit(stop);
        hold_bit(1'b1);
        @(negedge clk);
    endtask

    task automatic read_buf();
        @(negedge clk); rd_buf = 1'b1;
        @(negedge clk); rd_buf = 1'b0;
        chk("R11 irq after read", rx_irq, 0);
    endtask

    task automatic t_reset();
        chk("R1 irq", rx_irq, 0);
        chk("R1 ovr", rx_ovr, 0);
    endtask

    task automatic t_nine_unfiltered();
        nine_bit = 1'b1; addr_filt = 1'b0;
        send(8'hA5, 1'b0, 1'b1, 1'b1);
        chk("R2 irq", rx_irq, 1);
        chk("R2 data", rx_data, 8'hA5);
        chk("R5 bit9", rx_bit9, 0);
        chk("R9 ferr clean", rx_ferr, 0);
        read_buf();
    endtask

    task automatic t_filter();
        addr_filt = 1'b1;
        send(8'h3C, 1'b0, 1'b1, 1'b1);
        chk("R3 data frame dropped", rx_irq, 0);
        send(8'h42, 1'b1, 1'b1, 1'b1);
        chk("R4 irq", rx_irq, 1);
        chk("R4 data", rx_data, 8'h42);
        chk("R4 bit9", rx_bit9, 1);
        send(8'h99, 1'b0, 1'b1, 1'b0);
        chk("R10 no ovr on filtered", rx_ovr, 0);
        chk("R10 ferr unchanged", rx_ferr, 0);
        chk("R3 buffer kept", rx_data, 8'h42);
        read_buf();
        send(8'h77, 1'b0, 1'b1, 1'b0);
        chk("R10 irq stays 0", rx_irq, 0);
        chk("R10 ferr stays 0", rx_ferr, 0);
    endtask

    task automatic t_overrun();
        addr_filt = 1'b0;
        send(8'h81, 1'b0, 1'b1, 1'b0);
        chk("R9 irq", rx_irq, 1);
        chk("R9 ferr", rx_ferr, 1);
        send(8'h7E, 1'b0, 1'b1, 1'b1);
        chk("R6 ovr", rx_ovr, 1);
        chk("R6 data kept", rx_data, 8'h81);
        read_buf();
        chk("R7 ovr sticky", rx_ovr, 1);
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk); rx_en = 1'b1;
        @(negedge clk);
        chk("R7 ovr cleared", rx_ovr, 0);
    endtask

    task automatic t_disabled();
        port_en = 1'b0;
        send(8'h55, 1'b1, 1'b1, 1'b1);
        chk("R8 port off", rx_irq, 0);
        port_en = 1'b1; sync_mode = 1'b1;
        send(8'h55, 1'b1, 1'b1, 1'b1);
        chk("R8 sync mode", rx_irq, 0);
        sync_mode = 1'b0;
    endtask

    task automatic t_eight_bit();
        nine_bit = 1'b0; addr_filt = 1'b1;
        send(8'h5A, 1'b0, 1'b0, 1'b1);
        chk("R12 irq", rx_irq, 1);
        chk("R12 data", rx_data, 8'h5A);
        chk("R12 bit9", rx_bit9, 0);
        read_buf();
        nine_bit = 1'b1; addr_filt = 1'b0;
    endtask

    task automatic t_glitch();
        @(negedge clk); rx_line = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R13 glitch ignored", rx_irq, 0);
        send(8'h11, 1'b1, 1'b1, 1'b1);
        chk("R13 next frame", rx_data, 8'h11);
        read_buf();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        t_reset();
        t_nine_unfiltered();
        t_filter();
        t_overrun();
        t_disabled();
        t_eight_bit();
        t_glitch();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule